// File: doc/BRIEF.md
# Segment Address Mapper

This block is the first stage of a DMA engine's command path. It turns a logical address, as a kernel sees it, into one or more physical memory requests. Software keeps a small table of segments up to date. A segment is installed when a buffer is allocated and removed when the buffer is freed. Each segment covers a power-of-two range of the logical space, which starts at 0x1_0000_0000 and spans 64 GB for each processing element. Each segment also carries its own mapping mode.

When a command is accepted, the block looks up the segment that holds the logical address. The segment's mode then decides what happens next:

- **Aggregated mode.** The block emits a single request toward the aggregated router. The request carries the full byte count.
- **Per-channel mode.** The block splits the access across the N local memory channels, where N is 4, 8 or 16. It emits one request per channel, each carrying 1/N of the bytes.

Requests leave one per cycle on a valid/ready handshake. The block counts the completions that come back and pulses done once every emitted request has completed. It accepts no new command until then. Data movement, routing and bandwidth are handled downstream.

Top module: `seg_mapper`

## Requirements
- R1: After reset, `req_valid`, `cmd_err` and `cmd_done` are low, `cmd_ready` is high, and no segment is valid.
- R2: A valid segment with base B and size field S (size = 2^S bytes) contains a logical address A exactly when B <= A < B + 2^S. The offset is A - B.
- R3: Aggregated mode (`ins_fanout` = 0). The accepted command yields exactly one request, which appears in the cycle after acceptance. Its fields are `req_pa` = aggregated base + offset, `req_len` = `cmd_len`, `req_dst` = the segment's destination id, and `req_is_chan` = 0.
- R4: Per-channel mode (`ins_fanout` = 1, channel field C in {2,3,4}, so N = 2^C). The command yields exactly N requests, for channels 0 to N-1 in order. The request for channel i has these fields:
  - `req_pa` = channel base[i] + (offset mod 2^(S-C));
  - `req_len` = `cmd_len` >> C;
  - `req_dst` = i;
  - `req_is_chan` = 1.
- R5: Handshake. A request is held unchanged while `req_valid` is high and `req_ready` is low. The next request follows in the cycle after a handshake, so at most one request leaves per cycle.
- R6: A command whose address is held by no valid segment still causes a one-cycle `cmd_err` pulse in the cycle after acceptance. It produces no request, and `cmd_ready` stays high.
- R7: Completion and busy behaviour:
  - `cmd_ready` is low from the cycle after a hitting command is accepted until `cmd_done` pulses.
  - `cmd_done` pulses for one cycle, in the cycle after the `cpl_valid` that completes the last emitted request (1 in aggregated mode, N in per-channel mode).
  - While busy, `cmd_valid` is ignored.
- R8: Install writes the entry at `ins_idx` and marks it valid; uninstall clears the valid bit at `rm_idx`. A removed segment no longer hits, and segments in other slots stay resident.
- R9: A channel-base write sets channel base `chb_ch` of segment `chb_seg`. It is used by later per-channel requests and changes no other slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Install a segment entry |
| ins_idx | input | 3 | Table slot to install |
| ins_fanout | input | 1 | 1 = per-channel mode, 0 = aggregated mode |
| ins_base | input | 37 | Segment logical base |
| ins_size_log2 | input | 6 | log2 of segment size in bytes |
| ins_ch_log2 | input | 3 | log2 of channel count (2, 3 or 4) |
| ins_agg_pa | input | 51 | Aggregated physical base |
| ins_agg_dst | input | 8 | Aggregated router id |
| rm_valid | input | 1 | Uninstall a segment |
| rm_idx | input | 3 | Table slot to uninstall |
| chb_valid | input | 1 | Write one channel base |
| chb_seg | input | 3 | Segment slot of the channel base |
| chb_ch | input | 4 | Channel index of the channel base |
| chb_pa | input | 51 | Channel physical base |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command may be accepted |
| cmd_la | input | 37 | Command logical address |
| cmd_len | input | 32 | Command byte count |
| cmd_err | output | 1 | Lookup miss pulse |
| req_valid | output | 1 | Physical request valid |
| req_ready | input | 1 | Downstream accepts request |
| req_pa | output | 51 | Request physical address |
| req_len | output | 32 | Request byte count |
| req_dst | output | 8 | Destination id (router id or channel index) |
| req_is_chan | output | 1 | 1 when the request targets a channel router |
| cpl_valid | input | 1 | One emitted request completed |
| cmd_done | output | 1 | Command fully completed pulse |

## Verification
The bench aims at these corner cases, each paired with the wrong behaviour it would catch:

- **Segment edges.** It probes the last byte inside a segment, the first byte past it, and an address just below the logical space. An off-by-one in the containment test would turn one of these into a wrong hit or a wrong miss.
- **Offsets past one channel's share.** In per-channel mode it picks offsets beyond a single channel's share. Dropping the modulo would push physical addresses past the channel slice.
- **Channel count.** It covers 4, 8 and 16 channels. Wrong count handling would emit one request too few or too many, or divide the byte count wrongly.
- **Handshake stalls.** Random back-pressure checks that stalled requests hold steady. A design that advanced without a handshake would skip channels.
- **Completion accounting.** Completions arrive with random gaps, and a command is offered while the block is busy. Wrong counting would fire done early or late, or accept the extra command.
- **Table changes.** An uninstall followed by a lookup, and a rewritten channel base, show whether table updates take effect.

// File: rtl/segmap_pkg.sv
package segmap_pkg;

    localparam int LA_W  = 37;   // logical address width (space ends below 0x11_0000_0000)
    localparam int PA_W  = 51;   // physical address width
    localparam int LEN_W = 32;   // byte count width
    localparam int DST_W = 8;    // destination id width
    localparam int SZL_W = 6;    // width of the log2 segment size field
    localparam int CHL_W = 3;    // width of the log2 channel count field

    typedef struct packed {
        logic             valid;
        logic             fanout;
        logic [LA_W-1:0]  base;
        logic [SZL_W-1:0] size_log2;
        logic [CHL_W-1:0] ch_log2;
        logic [PA_W-1:0]  agg_pa;
        logic [DST_W-1:0] agg_dst;
    } seg_entry_t;

    typedef struct packed {
        logic [PA_W-1:0]  pa;
        logic [LEN_W-1:0] len;
        logic [DST_W-1:0] dst;
        logic             is_chan;
    } phys_req_t;

    // True when la lies in [base, base + 2^szl).
    function automatic logic seg_contains(input logic [LA_W-1:0]  base,
                                          input logic [SZL_W-1:0] szl,
                                          input logic [LA_W-1:0]  la);
        logic [LA_W-1:0] rel;
        rel = la - base;
        return (la >= base) && ((rel >> szl) == '0);
    endfunction

    // Mask of the low 'bits' bits of a logical offset.
    function automatic logic [LA_W-1:0] low_mask(input logic [SZL_W-1:0] bits);
        return (LA_W'(1) << bits) - LA_W'(1);
    endfunction

endpackage

// File: rtl/segmap_table.sv
module segmap_table
    import segmap_pkg::*;
#(
    parameter int NSEG        = 8,
    parameter int MAX_CH_LOG2 = 4,
    localparam int SEG_IW     = $clog2(NSEG),
    localparam int NCH        = 1 << MAX_CH_LOG2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins_valid,
    input  logic [SEG_IW-1:0]      ins_idx,
    input  seg_entry_t             ins_entry,
    input  logic                   rm_valid,
    input  logic [SEG_IW-1:0]      rm_idx,
    input  logic                   chb_valid,
    input  logic [SEG_IW-1:0]      chb_seg,
    input  logic [MAX_CH_LOG2-1:0] chb_ch,
    input  logic [PA_W-1:0]        chb_pa,
    input  logic [LA_W-1:0]        lookup_la,
    output logic                   hit,
    output logic [SEG_IW-1:0]      hit_idx,
    output seg_entry_t             hit_entry,
    input  logic [SEG_IW-1:0]      rd_seg,
    input  logic [MAX_CH_LOG2-1:0] rd_ch,
    output logic [PA_W-1:0]        rd_pa
);

    seg_entry_t        tbl   [NSEG];
    logic [PA_W-1:0]   chbase[NSEG*NCH];
    logic [NSEG-1:0]   match;

    // Entry storage: uninstall first, install of the same slot wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSEG; i++) begin
                tbl[i] <= '0;
            end
        end else begin
            if (rm_valid) begin
                tbl[rm_idx].valid <= 1'b0;
            end
            if (ins_valid) begin
                tbl[ins_idx] <= ins_entry;
            end
        end
    end

    // Channel base storage, one slot per (segment, channel).
    always_ff @(posedge clk) begin
        if (chb_valid) begin
            chbase[{chb_seg, chb_ch}] <= chb_pa;
        end
    end

    assign rd_pa = chbase[{rd_seg, rd_ch}];

    // Parallel range compare across every slot.
    for (genvar g = 0; g < NSEG; g++) begin : g_cmp
        assign match[g] = tbl[g].valid &&
                          seg_contains(tbl[g].base, tbl[g].size_log2, lookup_la);
    end

    // Lowest matching slot wins.
    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = SEG_IW'(i);
            end
        end
    end

    assign hit_entry = tbl[hit_idx];

    AST_SEG_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R8

endmodule

// File: rtl/segmap_reqgen.sv
module segmap_reqgen
    import segmap_pkg::*;
#(
    parameter int NSEG        = 8,
    parameter int MAX_CH_LOG2 = 4,
    localparam int SEG_IW     = $clog2(NSEG),
    localparam int CNT_W      = MAX_CH_LOG2 + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_fire,
    input  logic [LA_W-1:0]        cmd_la,
    input  logic [LEN_W-1:0]       cmd_len,
    input  logic [SEG_IW-1:0]      hit_idx,
    input  seg_entry_t             hit_entry,
    output logic [SEG_IW-1:0]      rd_seg,
    output logic [MAX_CH_LOG2-1:0] rd_ch,
    input  logic [PA_W-1:0]        rd_pa,
    output logic [CNT_W-1:0]       req_total,
    output logic                   busy,
    output logic                   req_valid,
    input  logic                   req_ready,
    output phys_req_t              req
);

    typedef enum logic { GEN_IDLE, GEN_EMIT } gen_state_e;

    gen_state_e             st;
    logic [SEG_IW-1:0]      seg_q;
    logic [LA_W-1:0]        off_q;
    logic [LEN_W-1:0]       len_q;
    logic                   fan_q;
    logic [CHL_W-1:0]       chl_q;
    logic [SZL_W-1:0]       szl_q;
    logic [PA_W-1:0]        apa_q;
    logic [DST_W-1:0]       adst_q;
    logic [MAX_CH_LOG2-1:0] ch_q;
    logic [CNT_W-1:0]       tot_q;
    logic [CHL_W-1:0]       chl_eff;
    logic                   last;

    // Channel count is clamped to what the channel-base store holds.
    assign chl_eff   = (hit_entry.ch_log2 > CHL_W'(MAX_CH_LOG2)) ?
                       CHL_W'(MAX_CH_LOG2) : hit_entry.ch_log2;
    assign req_total = hit_entry.fanout ? (CNT_W'(1) << chl_eff) : CNT_W'(1);

    assign busy      = (st == GEN_EMIT);
    assign req_valid = busy;
    assign rd_seg    = seg_q;
    assign rd_ch     = ch_q;
    assign last      = (CNT_W'(ch_q) == tot_q - CNT_W'(1));

    always_comb begin
        if (fan_q) begin
            req.pa      = rd_pa + PA_W'(off_q & low_mask(szl_q - SZL_W'(chl_q)));
            req.len     = len_q >> chl_q;
            req.dst     = DST_W'(ch_q);
            req.is_chan = 1'b1;
        end else begin
            req.pa      = apa_q + PA_W'(off_q);
            req.len     = len_q;
            req.dst     = adst_q;
            req.is_chan = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= GEN_IDLE;
            seg_q  <= '0;
            off_q  <= '0;
            len_q  <= '0;
            fan_q  <= 1'b0;
            chl_q  <= '0;
            szl_q  <= '0;
            apa_q  <= '0;
            adst_q <= '0;
            ch_q   <= '0;
            tot_q  <= '0;
        end else if (st == GEN_IDLE) begin
            if (cmd_fire) begin
                st     <= GEN_EMIT;
                seg_q  <= hit_idx;
                off_q  <= cmd_la - hit_entry.base;
                len_q  <= cmd_len;
                fan_q  <= hit_entry.fanout;
                chl_q  <= chl_eff;
                szl_q  <= hit_entry.size_log2;
                apa_q  <= hit_entry.agg_pa;
                adst_q <= hit_entry.agg_dst;
                ch_q   <= '0;
                tot_q  <= req_total;
            end
        end else if (req_ready) begin
            if (last) begin
                st <= GEN_IDLE;
            end else begin
                ch_q <= ch_q + 1'b1;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req)); // R5
    AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> CNT_W'(ch_q) < tot_q); // R4
    AST_FIRE_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |-> hit_entry.valid && !busy); // R2

endmodule

// File: rtl/segmap_cpl.sv
module segmap_cpl #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preset,
    input  logic [CNT_W-1:0] preset_n,
    input  logic             cpl_valid,
    output logic             pending,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    assign pending = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= cpl_valid && (cnt == CNT_W'(1));
            if (preset) begin
                cnt <= preset_n;
            end else if (cpl_valid && pending) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_NO_EXTRA_CPL: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> pending); // R7
    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        done |-> !pending); // R7

endmodule

// File: rtl/seg_mapper.sv
module seg_mapper
    import segmap_pkg::*;
#(
    parameter int NSEG        = 8,
    parameter int MAX_CH_LOG2 = 4,
    localparam int SEG_IW     = $clog2(NSEG),
    localparam int CNT_W      = MAX_CH_LOG2 + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins_valid,
    input  logic [SEG_IW-1:0]      ins_idx,
    input  logic                   ins_fanout,
    input  logic [LA_W-1:0]        ins_base,
    input  logic [SZL_W-1:0]       ins_size_log2,
    input  logic [CHL_W-1:0]       ins_ch_log2,
    input  logic [PA_W-1:0]        ins_agg_pa,
    input  logic [DST_W-1:0]       ins_agg_dst,
    input  logic                   rm_valid,
    input  logic [SEG_IW-1:0]      rm_idx,
    input  logic                   chb_valid,
    input  logic [SEG_IW-1:0]      chb_seg,
    input  logic [MAX_CH_LOG2-1:0] chb_ch,
    input  logic [PA_W-1:0]        chb_pa,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [LA_W-1:0]        cmd_la,
    input  logic [LEN_W-1:0]       cmd_len,
    output logic                   cmd_err,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [PA_W-1:0]        req_pa,
    output logic [LEN_W-1:0]       req_len,
    output logic [DST_W-1:0]       req_dst,
    output logic                   req_is_chan,
    input  logic                   cpl_valid,
    output logic                   cmd_done
);

    seg_entry_t             ins_entry;
    seg_entry_t             hit_entry;
    phys_req_t              req;
    logic                   hit;
    logic [SEG_IW-1:0]      hit_idx;
    logic [SEG_IW-1:0]      rd_seg;
    logic [MAX_CH_LOG2-1:0] rd_ch;
    logic [PA_W-1:0]        rd_pa;
    logic [CNT_W-1:0]       req_total;
    logic                   gen_busy;
    logic                   pending;
    logic                   accept;
    logic                   fire;

    always_comb begin
        ins_entry.valid     = 1'b1;
        ins_entry.fanout    = ins_fanout;
        ins_entry.base      = ins_base;
        ins_entry.size_log2 = ins_size_log2;
        ins_entry.ch_log2   = ins_ch_log2;
        ins_entry.agg_pa    = ins_agg_pa;
        ins_entry.agg_dst   = ins_agg_dst;
    end

    assign cmd_ready = !gen_busy && !pending;
    assign accept    = cmd_valid && cmd_ready;
    assign fire      = accept && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= accept && !hit;
        end
    end

    segmap_table #(.NSEG(NSEG), .MAX_CH_LOG2(MAX_CH_LOG2)) u_table (
        .clk       (clk),
        .rst       (rst),
        .ins_valid (ins_valid),
        .ins_idx   (ins_idx),
        .ins_entry (ins_entry),
        .rm_valid  (rm_valid),
        .rm_idx    (rm_idx),
        .chb_valid (chb_valid),
        .chb_seg   (chb_seg),
        .chb_ch    (chb_ch),
        .chb_pa    (chb_pa),
        .lookup_la (cmd_la),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_entry (hit_entry),
        .rd_seg    (rd_seg),
        .rd_ch     (rd_ch),
        .rd_pa     (rd_pa)
    );

    segmap_reqgen #(.NSEG(NSEG), .MAX_CH_LOG2(MAX_CH_LOG2)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .cmd_fire  (fire),
        .cmd_la    (cmd_la),
        .cmd_len   (cmd_len),
        .hit_idx   (hit_idx),
        .hit_entry (hit_entry),
        .rd_seg    (rd_seg),
        .rd_ch     (rd_ch),
        .rd_pa     (rd_pa),
        .req_total (req_total),
        .busy      (gen_busy),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req       (req)
    );

    segmap_cpl #(.CNT_W(CNT_W)) u_cpl (
        .clk       (clk),
        .rst       (rst),
        .preset    (fire),
        .preset_n  (req_total),
        .cpl_valid (cpl_valid),
        .pending   (pending),
        .done      (cmd_done)
    );

    assign req_pa      = req.pa;
    assign req_len     = req.len;
    assign req_dst     = req.dst;
    assign req_is_chan = req.is_chan;

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !req_valid && cmd_ready); // R6
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> cmd_ready); // R7
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(cmd_valid && cmd_ready)); // R3

endmodule

// File: tb/tb_seg_mapper.sv
module tb_seg_mapper;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 0;
    logic [2:0]  ins_idx = 0;
    logic        ins_fanout = 0;
    logic [36:0] ins_base = 0;
    logic [5:0]  ins_size_log2 = 0;
    logic [2:0]  ins_ch_log2 = 0;
    logic [50:0] ins_agg_pa = 0;
    logic [7:0]  ins_agg_dst = 0;
    logic        rm_valid = 0;
    logic [2:0]  rm_idx = 0;
    logic        chb_valid = 0;
    logic [2:0]  chb_seg = 0;
    logic [3:0]  chb_ch = 0;
    logic [50:0] chb_pa = 0;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [36:0] cmd_la = 0;
    logic [31:0] cmd_len = 0;
    logic        cmd_err;
    logic        req_valid;
    logic        req_ready = 0;
    logic [50:0] req_pa;
    logic [31:0] req_len;
    logic [7:0]  req_dst;
    logic        req_is_chan;
    logic        cpl_valid = 0;
    logic        cmd_done;

    int errors = 0;
    int checks = 0;
    bit ended  = 0;

    // Bench-side model of the installed table.
    bit          m_valid[8];
    bit          m_fan  [8];
    logic [36:0] m_base [8];
    int          m_szl  [8];
    int          m_chl  [8];
    logic [50:0] m_agg  [8];
    logic [7:0]  m_dst  [8];
    logic [50:0] m_chb  [8][16];

    seg_mapper dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [36:0] slot_base(input int j);
        return 37'h01_0000_0000 + (37'(j) << 21);
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic int find_seg(input logic [36:0] la);
        for (int s = 0; s < 8; s++) begin
            if (m_valid[s] && la >= m_base[s] &&
                ((la - m_base[s]) >> m_szl[s]) == 0) return s;
        end
        return -1;
    endfunction

    function automatic logic [50:0] exp_pa(input int s, input int k, input logic [36:0] off);
        logic [36:0] msk;
        if (m_fan[s]) begin
            msk = (37'd1 << (m_szl[s] - m_chl[s])) - 37'd1;
            return m_chb[s][k] + 51'(off & msk);
        end
        return m_agg[s] + 51'(off);
    endfunction

    task automatic install(input int idx, input bit fan, input logic [36:0] base,
                           input int szl, input int chl,
                           input logic [50:0] apa, input logic [7:0] adst);
        @(negedge clk);
        ins_valid = 1; ins_idx = 3'(idx); ins_fanout = fan; ins_base = base;
        ins_size_log2 = 6'(szl); ins_ch_log2 = 3'(chl);
        ins_agg_pa = apa; ins_agg_dst = adst;
        @(negedge clk);
        ins_valid = 0;
        m_valid[idx] = 1; m_fan[idx] = fan; m_base[idx] = base;
        m_szl[idx] = szl; m_chl[idx] = chl; m_agg[idx] = apa; m_dst[idx] = adst;
    endtask

    task automatic set_chb(input int s, input int c, input logic [50:0] pa);
        @(negedge clk);
        chb_valid = 1; chb_seg = 3'(s); chb_ch = 4'(c); chb_pa = pa;
        @(negedge clk);
        chb_valid = 0;
        m_chb[s][c] = pa;
    endtask

    task automatic remove(input int s);
        @(negedge clk);
        rm_valid = 1; rm_idx = 3'(s);
        @(negedge clk);
        rm_valid = 0;
        m_valid[s] = 0;
    endtask

    task automatic rand_bases(input int s);
        for (int c = 0; c < 16; c++) begin
            set_chb(s, c, {19'($urandom), $urandom});
        end
    endtask

    // Issue one command and check everything it produces at the ports.
    task automatic run_cmd(input logic [36:0] la, input logic [31:0] len, input bit busy_probe);
        int s;
        int n;
        int k;
        bit hs;
        string tg;
        logic [36:0] off;
        s = find_seg(la);
        @(negedge clk);
        cmd_valid = 1; cmd_la = la; cmd_len = len;
        @(negedge clk);
        cmd_valid = 0;
        if (s < 0) begin
            chk("R6 err pulse", 64'(cmd_err), 1);
            chk("R6 no request", 64'(req_valid), 0);
            chk("R6 ready kept", 64'(cmd_ready), 1);
            @(negedge clk);
            chk("R6 err one cycle", 64'(cmd_err), 0);
            chk("R6 still no request", 64'(req_valid), 0);
            return;
        end
        tg = m_fan[s] ? "R4" : "R3";
        chk("R7 busy after accept", 64'(cmd_ready), 0);
        chk("R2 hit gives no err", 64'(cmd_err), 0);
        off = la - m_base[s];
        n = m_fan[s] ? (1 << m_chl[s]) : 1;
        k = 0;
        while (k < n) begin
            chk({tg, " R5 req_valid"}, 64'(req_valid), 1);
            chk({tg, " pa"}, 64'(req_pa), 64'(exp_pa(s, k, off)));
            chk({tg, " len"}, 64'(req_len), m_fan[s] ? 64'(len >> m_chl[s]) : 64'(len));
            chk({tg, " dst"}, 64'(req_dst), m_fan[s] ? 64'(k) : 64'(m_dst[s]));
            chk({tg, " is_chan"}, 64'(req_is_chan), 64'(m_fan[s]));
            req_ready = (($urandom % 4) != 0);
            @(posedge clk);
            hs = req_ready;
            @(negedge clk);
            if (hs) k++;
        end
        req_ready = 0;
        chk({tg, " request count"}, 64'(req_valid), 0);
        chk("R7 busy until done", 64'(cmd_ready), 0);
        for (int c = 0; c < n; c++) begin
            repeat ($urandom % 3) @(negedge clk);
            if (busy_probe) cmd_valid = (c != n - 1);
            cmd_la = m_base[0] + 37'h40;
            cpl_valid = 1;
            @(negedge clk);
            cpl_valid = 0;
            if (c != n - 1) begin
                chk("R7 no early done", 64'(cmd_done), 0);
                chk("R7 ignores cmd while busy", 64'(req_valid), 0);
            end
        end
        cmd_valid = 0;
        chk("R7 done pulse", 64'(cmd_done), 1);
        chk("R7 ready at done", 64'(cmd_ready), 1);
        @(negedge clk);
        chk("R7 done one cycle", 64'(cmd_done), 0);
        chk("R7 busy command not taken", 64'(req_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 req_valid", 64'(req_valid), 0);
        chk("R1 cmd_err", 64'(cmd_err), 0);
        chk("R1 cmd_done", 64'(cmd_done), 0);
        chk("R1 cmd_ready", 64'(cmd_ready), 1);
        run_cmd(slot_base(0), 32'd256, 0);             // R1: empty table misses

        install(0, 0, slot_base(0), 16, 0, 51'h123_4567_8000, 8'hA5);
        install(1, 1, slot_base(1), 12, 3, 51'h0, 8'h00);
        install(2, 1, slot_base(2), 14, 2, 51'h0, 8'h00);
        install(3, 1, slot_base(3), 20, 4, 51'h0, 8'h00);
        for (int c = 0; c < 16; c++) begin
            set_chb(1, c, 51'h4_0000_0000 + 51'(c) * 51'h1000_0000);
        end
        rand_bases(2);
        rand_bases(3);

        run_cmd(slot_base(0) + 37'h1234, 32'd4096, 0);        // R3
        run_cmd(slot_base(1) + 37'h7FF, 32'd4096, 0);         // R4 offset past one share
        run_cmd(slot_base(1) + 37'd4095, 32'd512, 0);         // R2 last byte
        run_cmd(slot_base(1) + 37'd4096, 32'd512, 0);         // R2 one past end
        run_cmd(slot_base(0) - 37'd1, 32'd64, 0);             // R2 below space
        run_cmd(slot_base(2) + 37'h2345, 32'd1024, 1);        // R7 busy probe, 4 channels
        run_cmd(slot_base(3) + 37'h8_1234, 32'd8192, 0);      // R4 16 channels
        set_chb(1, 5, 51'h7_ABCD_0000);                       // R9
        run_cmd(slot_base(1) + 37'h10, 32'd256, 0);           // R9 new base used
        remove(2);
        run_cmd(slot_base(2) + 37'h10, 32'd256, 0);           // R8 removed misses
        run_cmd(slot_base(3) + 37'h10, 32'd256, 0);           // R8 others resident

        for (int j = 4; j < 8; j++) begin
            install(j, ($urandom % 2) == 1, slot_base(j), 12 + int'($urandom % 9),
                    2 + int'($urandom % 3), {19'($urandom), $urandom}, 8'($urandom));
            rand_bases(j);
        end
        for (int t = 0; t < 60; t++) begin
            int s;
            logic [36:0] la;
            s = int'($urandom % 8);
            if (($urandom % 6) == 0) begin
                la = slot_base(s) + (37'd1 << 20) + 37'($urandom % 4096);
            end else begin
                la = slot_base(s) + (37'($urandom) & ((37'd1 << (m_szl[s] > 0 ? m_szl[s] : 1)) - 37'd1));
            end
            run_cmd(la, 32'($urandom % 1024) * 32'd64, (t % 7) == 0);
        end
        finish_run();
    end

endmodule